// File: doc/BRIEF.md
# Pipeline Stage Handshake Chain

This block is a chain of pipeline slots. Each slot holds at most one instruction record: an opcode, a format kind, three operand words and one timestamp per slot. A record enters at the head through a valid/ready handshake. It moves one slot further only when three conditions hold in the same cycle: the slot is occupied, the slot's own work is finished, and the next slot (or the consumer, for the last slot) can take it. The per-slot work is modelled as a busy time of `WORK_CYCLES` cycles after each capture. Whenever a record leaves a slot, the slot writes the current value of a free-running 32-bit cycle counter into that record's timestamp for its own position.

A squash vector lets any slot begin a flush. The slot that raises it is emptied, and the flush is passed down so that every slot after it is emptied in the same cycle. Slots before the initiator are left alone. A flush outranks a transfer: a flushed slot neither sends nor accepts in that cycle. Whenever the output is not offering a record, it shows the empty record, which has the no-operation opcode, the invalid kind, zero operands and zero timestamps.

Top module: `stage_chain`

## Requirements
- R1: After reset every slot is empty and the cycle counter is 0. In the first cycle out of reset `in_ready` is 1 and `out_valid` is 0.
- R2: A slot passes its record on only when it is occupied, its work is done and the receiving side is ready. `in_ready` is 1 exactly when slot 0 is not flushed and is either empty or passing its record on in that cycle.
- R3: A captured record stays busy for `WORK_CYCLES` cycles before it may leave its slot. In an otherwise empty chain whose output is always ready, a record leaves the chain `N_STAGES*(WORK_CYCLES+1)` cycles after it is accepted.
- R4: While the output is stalled and no squash is raised, the offered record stays valid and its opcode, kind and operands do not change.
- R5: The cycle counter is 32 bits wide, is 0 in the first cycle after reset and increases by 1 every cycle. `out_stamps[k*32 +: 32]` holds the counter value of the cycle in which the record left slot k. The last slot's field shows the current counter value while the record is offered.
- R6: `squash[k]` empties slot k and every slot with a higher index in that cycle. Records in lower slots are kept and are delivered later in their original order.
- R7: A flushed slot neither accepts nor delivers in the squash cycle, and the upstream record it would have received stays where it is. With `squash[0]` raised, `in_ready` is 0.
- R8: When `out_valid` is 0, the outputs show the empty record: `out_op` = 0 (no-operation), `out_kind` = 3 (invalid), operands 0 and all stamps 0. The kind codes are R=0, I=1, J=2, invalid=3, and they pass through unchanged.
- R9: Records leave the chain in the order they were accepted, with opcode, kind and operands unchanged, and none is lost or duplicated unless it is squashed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new record is offered at the head |
| in_ready | output | 1 | Slot 0 accepts the offered record this cycle |
| in_op | input | OP_W (6) | Opcode of the offered record |
| in_kind | input | 2 | Format kind of the offered record |
| in_a | input | DATA_W (32) | First operand |
| in_b | input | DATA_W (32) | Second operand |
| in_c | input | DATA_W (32) | Third operand |
| squash | input | N_STAGES | Per-slot flush request; bit k empties slot k and every slot after it |
| out_valid | output | 1 | The last slot offers a finished record |
| out_ready | input | 1 | The consumer takes the offered record |
| out_op | output | OP_W (6) | Opcode of the offered record |
| out_kind | output | 2 | Format kind of the offered record |
| out_a | output | DATA_W (32) | First operand out |
| out_b | output | DATA_W (32) | Second operand out |
| out_c | output | DATA_W (32) | Third operand out |
| out_stamps | output | N_STAGES*32 | Departure cycle for each slot, slot k in bits k*32 +: 32 |

## Verification
A squash and a handoff can land in the same cycle. When that happens the squash must win without costing the upstream record its place. The bench provokes this by raising `squash[1]` in exactly the cycle in which a record in slot 0 finishes its busy time and would move on. It then judges the outcome by the record's end-to-end latency, which should be exactly one cycle longer than the undisturbed figure, and by the per-cycle reference model, which also covers the cycle of the squash. A second case raises `squash[0]` while a record is offered at the head, and checks that the record is refused in that cycle and accepted in the next one.

// File: rtl/stage_pkg.sv
`timescale 1ns/1ps
package stage_pkg;

    localparam int OP_W    = 6;
    localparam int DATA_W  = 32;
    localparam int STAMP_W = 32;

    localparam logic [OP_W-1:0] OP_NOP = '0;

    typedef enum logic [1:0] {
        KIND_R   = 2'd0,
        KIND_I   = 2'd1,
        KIND_J   = 2'd2,
        KIND_INV = 2'd3
    } kind_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        kind_e             kind;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
    } rec_t;

    localparam rec_t REC_EMPTY = '{op: OP_NOP, kind: KIND_INV, a: '0, b: '0, c: '0};

endpackage

// File: rtl/cycle_count.sv
`timescale 1ns/1ps
module cycle_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    typedef struct packed {
        logic [W-1:0] value;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.value = c_q.value + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.value;

endmodule

// File: rtl/stage_slot.sv
`timescale 1ns/1ps
module stage_slot
    import stage_pkg::*;
#(
    parameter int N_STAGES    = 4,
    parameter int IDX         = 0,
    parameter int WORK_CYCLES = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [STAMP_W-1:0]                cycle,
    input  logic                              up_valid,
    output logic                              up_ready,
    input  rec_t                              up_rec,
    input  logic [N_STAGES-1:0][STAMP_W-1:0]  up_stamps,
    output logic                              dn_valid,
    input  logic                              dn_ready,
    output rec_t                              dn_rec,
    output logic [N_STAGES-1:0][STAMP_W-1:0]  dn_stamps
);

    localparam int CNT_W = (WORK_CYCLES > 0) ? $clog2(WORK_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(WORK_CYCLES);

    typedef struct packed {
        logic                             valid;
        logic [CNT_W-1:0]                 busy;
        rec_t                             rec;
        logic [N_STAGES-1:0][STAMP_W-1:0] stamps;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{valid: 1'b0, busy: '0, rec: REC_EMPTY, stamps: '0};

    slot_t s_d, s_q;
    logic  done, fire, take;

    always_comb begin
        // Status: the stage's own work is finished once the busy count drains.
        done      = (s_q.busy == '0);
        dn_valid  = s_q.valid && done && !flush;
        fire      = dn_valid && dn_ready;
        up_ready  = !flush && (!s_q.valid || fire);
        take      = up_valid && up_ready;

        dn_rec    = REC_EMPTY;
        dn_stamps = '0;
        if (dn_valid) begin
            dn_rec         = s_q.rec;
            dn_stamps      = s_q.stamps;
            dn_stamps[IDX] = cycle;
        end

        s_d = s_q;
        if (s_q.valid && !done) begin
            s_d.busy = s_q.busy - 1'b1;
        end
        if (fire) begin
            s_d = SLOT_EMPTY;
        end
        if (take) begin
            s_d.valid  = 1'b1;
            s_d.busy   = BUSY_LOAD;
            s_d.rec    = up_rec;
            s_d.stamps = up_stamps;
        end
        // Flush outranks every other update.
        if (flush) begin
            s_d = SLOT_EMPTY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SLOT_EMPTY;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/stage_chain.sv
`timescale 1ns/1ps
module stage_chain
    import stage_pkg::*;
#(
    parameter int N_STAGES    = 4,
    parameter int WORK_CYCLES = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [OP_W-1:0]               in_op,
    input  logic [1:0]                    in_kind,
    input  logic [DATA_W-1:0]             in_a,
    input  logic [DATA_W-1:0]             in_b,
    input  logic [DATA_W-1:0]             in_c,
    input  logic [N_STAGES-1:0]           squash,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [OP_W-1:0]               out_op,
    output logic [1:0]                    out_kind,
    output logic [DATA_W-1:0]             out_a,
    output logic [DATA_W-1:0]             out_b,
    output logic [DATA_W-1:0]             out_c,
    output logic [N_STAGES*STAMP_W-1:0]   out_stamps
);

    typedef logic [N_STAGES-1:0][STAMP_W-1:0] stamps_t;

    logic [STAMP_W-1:0]  cycle;
    logic [N_STAGES-1:0] flush;
    logic                vld [N_STAGES+1];
    logic                rdy [N_STAGES+1];
    rec_t                rec [N_STAGES+1];
    stamps_t             stp [N_STAGES+1];

    cycle_count #(.W(STAMP_W)) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle)
    );

    // A flush raised at slot k reaches every later slot in the same cycle.
    always_comb begin
        flush[0] = squash[0];
        for (int k = 1; k < N_STAGES; k++) begin
            flush[k] = squash[k] | flush[k-1];
        end
    end

    assign vld[0]   = in_valid;
    assign rec[0]   = '{op: in_op, kind: kind_e'(in_kind), a: in_a, b: in_b, c: in_c};
    assign stp[0]   = '0;
    assign in_ready = rdy[0];
    assign rdy[N_STAGES] = out_ready;

    for (genvar k = 0; k < N_STAGES; k++) begin : g_slot
        stage_slot #(
            .N_STAGES    (N_STAGES),
            .IDX         (k),
            .WORK_CYCLES (WORK_CYCLES)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush[k]),
            .cycle     (cycle),
            .up_valid  (vld[k]),
            .up_ready  (rdy[k]),
            .up_rec    (rec[k]),
            .up_stamps (stp[k]),
            .dn_valid  (vld[k+1]),
            .dn_ready  (rdy[k+1]),
            .dn_rec    (rec[k+1]),
            .dn_stamps (stp[k+1])
        );
    end

    assign out_valid  = vld[N_STAGES];
    assign out_op     = rec[N_STAGES].op;
    assign out_kind   = rec[N_STAGES].kind;
    assign out_a      = rec[N_STAGES].a;
    assign out_b      = rec[N_STAGES].b;
    assign out_c      = rec[N_STAGES].c;
    assign out_stamps = stp[N_STAGES];

endmodule

// File: rtl/stage_chain_chk.sv
`timescale 1ns/1ps
module stage_chain_chk
    import stage_pkg::*;
#(
    parameter int N_STAGES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_ready,
    input logic [N_STAGES-1:0]         squash,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [OP_W-1:0]             out_op,
    input logic [1:0]                  out_kind,
    input logic [DATA_W-1:0]           out_a,
    input logic [DATA_W-1:0]           out_b,
    input logic [DATA_W-1:0]           out_c,
    input logic [N_STAGES*STAMP_W-1:0] out_stamps
);

    localparam int LAST = N_STAGES - 1;

    logic [STAMP_W-1:0] ref_cycle;
    logic [STAMP_W-1:0] last_stamp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_cycle <= '0;
        else        ref_cycle <= ref_cycle + 1'b1;
    end

    assign last_stamp = out_stamps[LAST*STAMP_W +: STAMP_W];

    assert_empty_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !(|squash)) |=>
            ((|squash) || (out_valid && $stable(out_op) && $stable(out_kind)
                           && $stable(out_a) && $stable(out_b) && $stable(out_c))));

    assert_stamp_is_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (last_stamp == ref_cycle));

    assert_squash_empties_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|squash) |=> !out_valid);

    assert_squash_blocks_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash[0] |-> !in_ready);

    assert_idle_shows_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_op == OP_NOP && out_kind == 2'd3 && out_a == '0
                        && out_b == '0 && out_c == '0 && out_stamps == '0));

endmodule

bind stage_chain stage_chain_chk #(.N_STAGES(N_STAGES)) u_chk (.*);

// File: tb/stage_chain_test.sv
`timescale 1ns/1ps
module stage_chain_test;
    import stage_pkg::*;

    localparam int N  = 4;
    localparam int W  = 1;
    localparam int SW = STAMP_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                drv_valid = 1'b0;
    logic [OP_W-1:0]     drv_op = '0;
    logic [1:0]          drv_kind = '0;
    logic [DATA_W-1:0]   drv_a = '0, drv_b = '0, drv_c = '0;
    logic [N-1:0]        squash = '0;
    logic                out_ready = 1'b0;
    logic                in_ready, out_valid;
    logic [OP_W-1:0]     out_op;
    logic [1:0]          out_kind;
    logic [DATA_W-1:0]   out_a, out_b, out_c;
    logic [N*SW-1:0]     out_stamps;

    always #10 clk = ~clk;

    stage_chain #(.N_STAGES(N), .WORK_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(drv_valid), .in_ready(in_ready),
        .in_op(drv_op), .in_kind(drv_kind), .in_a(drv_a), .in_b(drv_b), .in_c(drv_c),
        .squash(squash),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_op(out_op), .out_kind(out_kind), .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .out_stamps(out_stamps)
    );

    // Reference model state
    bit                       m_v   [N];
    int                       m_cnt [N];
    rec_t                     m_rec [N];
    logic [N-1:0][SW-1:0]     m_ts  [N];
    int                       cyc = 0;
    int                       acc_cyc  [64];
    int                       fire_cyc [64];

    int   n_chk = 0, n_err = 0;
    bit   finished = 0, auto_inc = 0;
    bit   s_in_ready, s_out_valid;
    rec_t s_rec, h_rec;
    logic [N*SW-1:0] s_stamps;

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_fields();
        drv_kind = drv_op[1:0];
        drv_a    = 32'(drv_op) * 32'd3 + 32'd1;
        drv_b    = ~32'(drv_op);
        drv_c    = {drv_op, 26'h2AAAAAA};
    endtask

    task automatic clear_slot(int k);
        m_v[k] = 0; m_cnt[k] = 0; m_rec[k] = REC_EMPTY; m_ts[k] = '0;
    endtask

    task automatic step();
        bit fl [N];
        bit fr [N];
        bit rd [N+1];
        bit exp_ov, in_acc;
        rec_t er;
        logic [N-1:0][SW-1:0] es;
        #5;
        for (int k = 0; k < N; k++) begin
            fl[k] = squash[k];
            if (k > 0 && fl[k-1]) fl[k] = 1;
        end
        rd[N] = out_ready;
        for (int k = N-1; k >= 0; k--) begin
            fr[k] = m_v[k] && m_cnt[k] == 0 && !fl[k] && rd[k+1];
            rd[k] = !fl[k] && (!m_v[k] || fr[k]);
        end
        exp_ov = m_v[N-1] && m_cnt[N-1] == 0 && !fl[N-1];
        er = REC_EMPTY;
        es = '0;
        if (exp_ov) begin
            er = m_rec[N-1];
            es = m_ts[N-1];
            es[N-1] = SW'(cyc);
        end
        s_in_ready  = in_ready;
        s_out_valid = out_valid;
        s_rec       = rec_t'({out_op, out_kind, out_a, out_b, out_c});
        s_stamps    = out_stamps;
        chk(in_ready === rd[0], "R2", "in_ready", 128'(in_ready), 128'(rd[0]));
        chk(out_valid === exp_ov, "R2", "out_valid", 128'(out_valid), 128'(exp_ov));
        chk(s_rec === er, "R9", "out record", 128'(s_rec), 128'(er));
        chk(out_stamps === es, "R5", "out_stamps", 128'(out_stamps), 128'(es));
        in_acc = drv_valid && rd[0];
        if (in_acc) acc_cyc[drv_op] = cyc;
        if (exp_ov && out_ready) fire_cyc[m_rec[N-1].op] = cyc;
        @(posedge clk);
        for (int k = N-1; k >= 0; k--) begin
            if (fl[k]) begin
                clear_slot(k);
            end else if (k == 0 && in_acc) begin
                m_v[0] = 1; m_cnt[0] = W; m_ts[0] = '0;
                m_rec[0] = rec_t'({drv_op, drv_kind, drv_a, drv_b, drv_c});
            end else if (k > 0 && fr[k-1]) begin
                m_v[k] = 1; m_cnt[k] = W;
                m_rec[k] = m_rec[k-1];
                m_ts[k] = m_ts[k-1];
                m_ts[k][k-1] = SW'(cyc);
            end else if (fr[k]) begin
                clear_slot(k);
            end else if (m_v[k] && m_cnt[k] > 0) begin
                m_cnt[k]--;
            end
        end
        cyc++;
        @(negedge clk);
        if (auto_inc && in_acc) begin
            drv_op = drv_op + 1'b1;
            set_fields();
        end
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin acc_cyc[i] = -1; fire_cyc[i] = -1; end
        for (int k = 0; k < N; k++) clear_slot(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Cycle 0 after reset
        step();
        chk(s_in_ready == 1, "R1", "in_ready after reset", 128'(s_in_ready), 128'(1));
        chk(s_out_valid == 0, "R1", "out_valid after reset", 128'(s_out_valid), 128'(0));
        chk(s_rec == REC_EMPTY, "R8", "idle record", 128'(s_rec), 128'(REC_EMPTY));
        chk(s_stamps == '0, "R8", "idle stamps", 128'(s_stamps), 128'(0));

        // Single record through an empty chain
        out_ready = 1; drv_valid = 1; drv_op = 6'd1; set_fields();
        step();
        drv_valid = 0;
        repeat (12) step();
        chk(acc_cyc[1] >= 0 && fire_cyc[1] - acc_cyc[1] == N*(W+1), "R3", "latency",
            128'(fire_cyc[1] - acc_cyc[1]), 128'(N*(W+1)));

        // Stream with an irregular output-ready pattern
        auto_inc = 1; drv_op = 6'd2; set_fields(); drv_valid = 1;
        for (int i = 0; i < 80 && acc_cyc[9] < 0; i++) begin
            out_ready = (i % 3) != 2;
            step();
        end
        drv_valid = 0; auto_inc = 0; out_ready = 1;
        repeat (20) step();
        for (int i = 3; i <= 9; i++) begin
            chk(fire_cyc[i-1] >= 0 && fire_cyc[i] > fire_cyc[i-1], "R9", "delivery order",
                128'(fire_cyc[i]), 128'(fire_cyc[i-1]));
        end

        // Fill the chain against a stalled output
        out_ready = 0; auto_inc = 1; drv_op = 6'd10; set_fields(); drv_valid = 1;
        for (int i = 0; i < 40 && acc_cyc[13] < 0; i++) step();
        drv_valid = 0; auto_inc = 0;
        repeat (4) step();
        chk(s_out_valid == 1, "R4", "valid under stall", 128'(s_out_valid), 128'(1));
        h_rec = s_rec;
        repeat (5) step();
        chk(s_out_valid == 1 && s_rec == h_rec, "R4", "record held", 128'(s_rec), 128'(h_rec));
        drv_valid = 1; drv_op = 6'd14; set_fields();
        step();
        chk(s_in_ready == 0, "R2", "in_ready when full", 128'(s_in_ready), 128'(0));
        drv_valid = 0;
        step();
        chk(acc_cyc[14] < 0, "R2", "record refused when full", 128'(acc_cyc[14]), 128'(-1));

        // Squash from slot 2 while full
        squash = 4'b0100;
        step();
        squash = '0;
        chk(s_out_valid == 0, "R7", "out_valid in squash cycle", 128'(s_out_valid), 128'(0));
        step();
        chk(s_out_valid == 0, "R6", "tail empty after squash", 128'(s_out_valid), 128'(0));
        out_ready = 1;
        repeat (20) step();
        chk(fire_cyc[10] < 0 && fire_cyc[11] < 0, "R6", "squashed records dropped",
            128'(fire_cyc[11]), 128'(-1));
        chk(fire_cyc[12] >= 0 && fire_cyc[13] > fire_cyc[12], "R6", "upstream records kept",
            128'(fire_cyc[13]), 128'(fire_cyc[12]));

        // Squash of slot 1 in the cycle slot 0 would hand off
        drv_valid = 1; drv_op = 6'd20; set_fields();
        step();
        drv_valid = 0;
        step();
        squash = 4'b0010;
        step();
        squash = '0;
        repeat (14) step();
        chk(acc_cyc[20] >= 0 && fire_cyc[20] - acc_cyc[20] == N*(W+1) + 1, "R7",
            "handoff deferred by squash", 128'(fire_cyc[20] - acc_cyc[20]), 128'(N*(W+1) + 1));

        // Squash of slot 0 while a record is offered
        drv_valid = 1; drv_op = 6'd30; set_fields(); squash = 4'b0001;
        step();
        squash = '0;
        chk(s_in_ready == 0 && acc_cyc[30] < 0, "R7", "entry blocked by squash",
            128'(s_in_ready), 128'(0));
        step();
        drv_valid = 0;
        chk(acc_cyc[30] >= 0, "R7", "entry after squash", 128'(acc_cyc[30]), 128'(cyc - 1));
        repeat (12) step();
        chk(fire_cyc[30] - acc_cyc[30] == N*(W+1), "R3", "latency after squash",
            128'(fire_cyc[30] - acc_cyc[30]), 128'(N*(W+1)));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule